// File: doc/BRIEF.md
# Systolic Packed-Byte Dot-Product Array

This block is a matrix-style multiply-accumulate engine. It has eight parallel lanes and a chain of four pipelined stages. Each lane carries one 32-bit partial sum per stage. A stage takes one 32-bit operand word pair per lane and splits both words into four signed 8-bit values. It multiplies matching byte pairs independently and adds the four products to the partial sum handed to it by the stage before. Stage 0 starts from an external initial accumulator value. Each stage therefore performs 32 byte multiplications and 32 accumulation additions per clock. With all four stages busy, the array does 256 operations per clock.

A caller presents one complete input set in a single cycle: operands for all four stages, eight initial accumulator words, and one valid bit. Internal skew registers hold back the operands of stage k by k cycles, so they meet the partial sum of the same set as it moves down the chain. A valid bit travels with the data. One new set may be accepted every clock. Eight 32-bit results come out together, qualified by an output valid.

Top module: `sysdot_array`

## Requirements
- R1: Every 32-bit operand word is treated as four signed two's-complement bytes at bit positions [8j+7:8j], j = 0..3. Byte j of an A word is multiplied only with byte j of the matching B word, and each product is sign-extended to 32 bits.
- R2: Each stage adds the four byte products of a lane to the partial sum of that lane from the previous stage. Stage 0 adds to the lane's initial accumulator. When all operands are zero, the initial accumulator passes through unchanged.
- R3: Lane i of the result, at bits [32i+31:32i], equals acc_in lane i plus the byte dot products from all four stages. Stage k, lane i operands sit at op_a/op_b bits [(8k+i)*32+31:(8k+i)*32]. Lanes do not affect one another.
- R4: All sums are modulo 2^32 and wrap with no saturation. For example, 0x7FFFFFFF + 1 gives 0x80000000, and 0x80000000 + (-1) gives 0x7FFFFFFF.
- R5: A set sampled with in_valid high at a rising edge shows on result, with out_valid high, right after the fourth rising edge counted from and including that sampling edge.
- R6: A new set may be accepted on every clock. Back-to-back sets each produce their own correct result on consecutive cycles.
- R7: out_valid is high exactly in the cycles that correspond, with the R5 latency, to edges where in_valid was sampled high. Gaps in the input appear as gaps in the output.
- R8: A synchronous active-high rst clears every valid bit. out_valid is low after a reset edge, and sets in flight at reset never appear.
- R9: Operand and accumulator values presented while in_valid is low produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the whole input set in this cycle |
| op_a | input | 1024 | A operands, stage k lane i word at (8k+i)*32 |
| op_b | input | 1024 | B operands, same layout as op_a |
| acc_in | input | 256 | Initial accumulator, lane i at 32i |
| out_valid | output | 1 | Result qualifier |
| result | output | 256 | Final sums, lane i at 32i |

## Verification
The latency assertion assumes the caller holds the input set stable through the sampling edge. It also assumes reset lasts long enough to fill the skew registers with defined data. The bench drives inputs only at falling edges and holds reset for four cycles with zero operands. The lane-wrap and pass-through assertions assume operand buses are never X once reset is released. The bench keeps every bus driven, and during idle gaps it drives random values rather than leaving buses undriven. Reset mid-stream is applied only at a falling edge, and the scoreboard drops the sets still in flight at that point.

// File: rtl/sysdot_pkg.sv
package sysdot_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int BYTES  = WORD_W / BYTE_W;

  // Signed packed-byte dot product of two words, wrapped to WORD_W bits.
  function automatic logic [WORD_W-1:0] byte_dot(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    logic [WORD_W-1:0]          s;
    logic signed [2*BYTE_W-1:0] p;
    s = '0;
    for (int j = 0; j < BYTES; j++) begin
      p = $signed(a[j*BYTE_W +: BYTE_W]) * $signed(b[j*BYTE_W +: BYTE_W]);
      s = s + {{(WORD_W-2*BYTE_W){p[2*BYTE_W-1]}}, p};
    end
    return s;
  endfunction
endpackage

// File: rtl/sysdot_skew.sv
module sysdot_skew #(
  parameter int DEPTH = 1,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q = d;
    end else begin : g_pipe
      logic [DEPTH-1:0][WIDTH-1:0] pipe;
      always_ff @(posedge clk) begin
        pipe[0] <= d;
        for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
      end
      assign q = pipe[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sysdot_stage.sv
module sysdot_stage
  import sysdot_pkg::*;
#(
  parameter  int LANES = 8,
  localparam int BUS_W = LANES * WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_in,
  input  logic [BUS_W-1:0] psum_in,
  input  logic [BUS_W-1:0] a_op,
  input  logic [BUS_W-1:0] b_op,
  output logic             v_out,
  output logic [BUS_W-1:0] psum_out
);
  logic [BUS_W-1:0] lane_sum;
  logic             opnds_zero;

  assign opnds_zero = (a_op == '0);

  generate
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [WORD_W-1:0] lane_dot;
      assign lane_dot = byte_dot(a_op[ln*WORD_W +: WORD_W], b_op[ln*WORD_W +: WORD_W]);
      assign lane_sum[ln*WORD_W +: WORD_W] = psum_in[ln*WORD_W +: WORD_W] + lane_dot;

      // R4
      lane_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (v_in && psum_in[ln*WORD_W +: WORD_W] == 32'h7fff_ffff && !lane_dot[WORD_W-1] && lane_dot != '0)
        |=> psum_out[ln*WORD_W + WORD_W - 1]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) v_out <= 1'b0;
    else     v_out <= v_in;
    psum_out <= lane_sum;
  end

  // R2
  zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    opnds_zero |=> psum_out == $past(psum_in));
endmodule

// File: rtl/sysdot_array.sv
module sysdot_array
  import sysdot_pkg::*;
#(
  parameter  int STAGES = 4,
  parameter  int LANES  = 8,
  localparam int BUS_W  = LANES * WORD_W,
  localparam int OPS_W  = STAGES * BUS_W,
  localparam int AGE_W  = $clog2(STAGES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OPS_W-1:0] op_a,
  input  logic [OPS_W-1:0] op_b,
  input  logic [BUS_W-1:0] acc_in,
  output logic             out_valid,
  output logic [BUS_W-1:0] result
);
  logic [STAGES:0][BUS_W-1:0] psum_chain;
  logic [STAGES:0]            v_chain;

  assign psum_chain[0] = acc_in;
  assign v_chain[0]    = in_valid;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic [2*BUS_W-1:0] ops_aligned;
      sysdot_skew #(.DEPTH(k), .WIDTH(2*BUS_W)) u_skew (
        .clk (clk),
        .d   ({op_a[k*BUS_W +: BUS_W], op_b[k*BUS_W +: BUS_W]}),
        .q   (ops_aligned)
      );
      sysdot_stage #(.LANES(LANES)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .v_in     (v_chain[k]),
        .psum_in  (psum_chain[k]),
        .a_op     (ops_aligned[2*BUS_W-1:BUS_W]),
        .b_op     (ops_aligned[BUS_W-1:0]),
        .v_out    (v_chain[k+1]),
        .psum_out (psum_chain[k+1])
      );
    end
  endgenerate

  assign out_valid = v_chain[STAGES];
  assign result    = psum_chain[STAGES];

  // Checker state: cycles since reset and a shadow of accepted valids.
  logic [AGE_W-1:0]  age;
  logic [STAGES-1:0] v_shadow;
  logic              shadow_ready;

  always_ff @(posedge clk) begin
    if (rst)                       age <= '0;
    else if (age != AGE_W'(STAGES)) age <= age + 1'b1;
    v_shadow <= {v_shadow[STAGES-2:0], in_valid};
  end
  assign shadow_ready = (age == AGE_W'(STAGES));

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    shadow_ready |-> out_valid == v_shadow[STAGES-1]);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/sysdot_array_bench.sv
module sysdot_array_bench;
  localparam int ST = 4;
  localparam int LN = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [1023:0] op_a, op_b;
  logic [255:0]  acc_in;
  logic          out_valid;
  logic [255:0]  result;

  always #10 clk = ~clk;

  sysdot_array u_sysdot_array (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .acc_in(acc_in), .out_valid(out_valid), .result(result)
  );

  typedef struct { longint due; logic [255:0] val; string tag; } exp_t;
  exp_t   q[$];
  longint nedge = 0;
  int     total = 0, bad = 0;
  bit     mon_on = 0, done = 0;
  logic [31:0] a_w[ST][LN], b_w[ST][LN], acc_w[LN];

  always @(posedge clk) nedge <= nedge + 1;

  function automatic longint sbyte(logic [7:0] x);
    return (x >= 8'd128) ? longint'(x) - 256 : longint'(x);
  endfunction

  function automatic logic [255:0] model();
    logic [255:0] r;
    for (int i = 0; i < LN; i++) begin
      longint s = longint'(acc_w[i]);
      for (int k = 0; k < ST; k++)
        for (int j = 0; j < 4; j++)
          s += sbyte(a_w[k][i][8*j +: 8]) * sbyte(b_w[k][i][8*j +: 8]);
      r[32*i +: 32] = s[31:0];
    end
    return r;
  endfunction

  task automatic clear_set();
    for (int i = 0; i < LN; i++) begin
      acc_w[i] = '0;
      for (int k = 0; k < ST; k++) begin a_w[k][i] = '0; b_w[k][i] = '0; end
    end
  endtask

  task automatic rand_set();
    for (int i = 0; i < LN; i++) begin
      acc_w[i] = $urandom;
      for (int k = 0; k < ST; k++) begin a_w[k][i] = $urandom; b_w[k][i] = $urandom; end
    end
  endtask

  task automatic send(string tag);
    for (int i = 0; i < LN; i++) begin
      acc_in[32*i +: 32] = acc_w[i];
      for (int k = 0; k < ST; k++) begin
        op_a[(k*LN+i)*32 +: 32] = a_w[k][i];
        op_b[(k*LN+i)*32 +: 32] = b_w[k][i];
      end
    end
    in_valid = 1'b1;
    q.push_back('{nedge + 4, model(), tag});
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      in_valid = 1'b0;
      for (int w = 0; w < 32; w++) begin op_a[32*w +: 32] = $urandom; op_b[32*w +: 32] = $urandom; end
      for (int w = 0; w < 8; w++) acc_in[32*w +: 32] = $urandom;
      @(negedge clk);
    end
  endtask

  // Monitor: valid timing each cycle, data on every expected result.
  always @(negedge clk) begin
    if (mon_on) begin
      bit exp_v;
      exp_v = (q.size() > 0) && (q[0].due == nedge);
      total++;
      if (out_valid !== exp_v) begin
        bad++;
        $display("FAIL R7 out_valid at edge %0d actual=%b expected=%b", nedge, out_valid, exp_v);
      end
      if (exp_v) begin
        total++;
        if (result !== q[0].val) begin
          bad++;
          $display("FAIL %s result actual=%h expected=%h", q[0].tag, result, q[0].val);
        end
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; acc_in = '0;
    repeat (4) @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin bad++; $display("FAIL R8 reset state actual=%b expected=0", out_valid); end
    rst = 1'b0; mon_on = 1;

    // R2: zero operands pass the accumulator through
    clear_set();
    for (int i = 0; i < LN; i++) acc_w[i] = 32'h1000 + i;
    send("R2");
    // R3: positive bytes, same in all stages: 4 * 70 per lane
    clear_set();
    for (int k = 0; k < ST; k++) for (int i = 0; i < LN; i++) begin
      a_w[k][i] = 32'h01020304; b_w[k][i] = 32'h05060708;
    end
    send("R3");
    // R1: signed byte corners
    clear_set();
    for (int i = 0; i < LN; i++) begin
      a_w[0][i] = 32'h80FF7F01; b_w[0][i] = 32'h80017FFF;
      a_w[2][i] = 32'hFF80FF80; b_w[2][i] = 32'hFF7F807F;
    end
    send("R1");
    // R4: wrap in both directions
    clear_set();
    acc_w[0] = 32'h7FFFFFFF; a_w[0][0] = 32'h1; b_w[0][0] = 32'h1;
    acc_w[1] = 32'h80000000; a_w[3][1] = 32'hFF; b_w[3][1] = 32'h1;
    send("R4");
    // R3: one nonzero slot per lane, stage = lane mod 4
    clear_set();
    for (int i = 0; i < LN; i++) begin a_w[i%ST][i] = 32'h00000003 << (8*(i/ST)); b_w[i%ST][i] = 32'h7F7F7F7F; end
    send("R3");
    idle(6);
    // R6: random back-to-back burst
    for (int n = 0; n < 40; n++) begin rand_set(); send("R6"); end
    idle(6);
    // R9: bubbles with random garbage between sets
    for (int n = 0; n < 24; n++) begin
      if (n % 3 == 2) idle(1);
      else begin rand_set(); send("R9"); end
    end
    idle(6);
    // R8: reset with sets in flight
    for (int n = 0; n < 3; n++) begin rand_set(); send("R8"); end
    rst = 1'b1; in_valid = 1'b0;
    begin
      exp_t keep[$];
      foreach (q[i]) if (q[i].due <= nedge) keep.push_back(q[i]);
      q = keep;
    end
    repeat (2) @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin bad++; $display("FAIL R8 in-reset actual=%b expected=0", out_valid); end
    rst = 1'b0;
    idle(6);
    rand_set(); send("R5");
    idle(6);
    total++;
    if (q.size() != 0) begin bad++; $display("FAIL R7 pending results actual=%0d expected=0", q.size()); end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule